// File: doc/BRIEF.md
# PMBus Target Alert and Communication-Fault Controller

This block is the transaction layer of an SMBus/PMBus target. A byte-level I2C target front end sits below it. The front end reports bus events to this block as single-cycle pulses: START, repeated START, STOP, an address byte, a written data byte, and "read byte consumed". In return the block gives an acknowledge decision and the next byte to transmit. From these events the block decides which addresses to claim. It decodes a small set of status and control command codes and keeps a communication-fault register. It also drives an open-drain style alert request, where a high enable pulls the shared line low.

The target answers the shared alert-response address 7'h0C, but only while it holds an unacknowledged alert. In that case it returns its own address shifted left by one with a zero low bit, and then drops the request. The block also enforces the transaction rules:
- A read addressed to the target straight after a START, with no command code before it, is a protocol error.
- Writes to read-only codes, and out-of-range values, are data errors.
- Undecoded codes are command errors.
- A bare clear-faults command empties the fault register.

The controller is one state machine:
- **ST_IDLE**: bus idle or between transactions.
- **ST_ADDR**: waiting for the address byte after a START or repeated START.
- **ST_CMD**: own address with write accepted; waiting for the command code.
- **ST_WDATA**: command code held; data bytes or a repeated START may follow.
- **ST_RD_REG**: returning register bytes of a legal Read Byte/Word.
- **ST_RD_ARA**: returning the alert-response byte.
- **ST_RD_BAD**: returning 0xFF after a protocol error, or after the alert byte has gone.
- **ST_SKIP**: not addressed; waiting for the next START or STOP.

The transitions are:
- START and repeated START go to ST_ADDR from any state.
- STOP goes to ST_IDLE from any state.
- In ST_ADDR:
  - an alert read goes to ST_RD_ARA;
  - an own write goes to ST_CMD;
  - an own read goes to ST_RD_REG when a command code came first, and to ST_RD_BAD otherwise;
  - any other address goes to ST_SKIP.
- ST_CMD goes to ST_WDATA on the command byte.
- ST_RD_ARA goes to ST_RD_BAD once its byte is consumed.

Top module: `pmbus_alert_target`

## Requirements
- R1: After reset, `ack_o` and `alert_pull_o` are 0. The communication register (code 0x7E) reads 0x00 and the run register (code 0x01) reads 0x00.
- R2: `ack_o` is updated in the cycle after each `ev_addr_i` or `ev_wdata_i` pulse. It is 1 for an address byte `{own,0}` and 0 for any address other than the own address or 0x0C. A refused address leaves the fault register and the alert unchanged.
- R3: Address byte 0x19 (0x0C with read) is acknowledged only while an alert is pending and is refused otherwise. Address byte 0x18 (0x0C with write) is always refused.
- R4: An acknowledged alert-response read returns `{own,1'b0}` (0x70 for own address 0x38). The alert is released in the cycle after that byte is consumed. A further 0x19 is then refused until a new fault occurs. The fault bits themselves stay set.
- R5: `{own,1}` as the first address after a START (Receive Byte) is acknowledged. It returns 0xFF, sets bit 6 of the communication register, and raises the alert.
- R6: A Read Byte sequence raises no fault. The sequence is `{own,0}`, a command code, a repeated START, then `{own,1}`. The bytes are returned as listed in R9.
- R7: A data byte written to code 0x78, 0x79 or 0x7E sets bit 6. Code 0x01 accepts only 0x00 or 0x80 as its first data byte. Any other value, or a second data byte, sets bit 6 and leaves the register unchanged.
- R8: Code 0x03 followed by STOP with no data byte clears the communication register and the pending alert. If a data byte follows 0x03, nothing is cleared and bit 6 is set.
- R9: The status reads return the following:
  - Code 0x78 returns a summary byte. Its bit 1 is the OR of all communication bits, and its other bits are 0.
  - Code 0x79 returns the summary byte first, then 0x00.
  - Code 0x7E returns the communication register.
  - Bytes beyond a register's length read 0xFF.
- R10: A command code other than 0x01, 0x03, 0x78, 0x79 or 0x7E sets bit 7 of the communication register. A read of such a code, or of 0x03, returns 0xFF.
- R11: `alert_pull_o` rises in the cycle after any fault-setting event, including a repeated fault. It stays high until an alert-response read completes or faults are cleared.
- R12: The own address is sampled from `own_addr_i` while reset is held. Later changes to that input have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; own address sampled while low |
| own_addr_i | input | 7 | Strapped 7-bit target address |
| ev_start_i | input | 1 | START seen (pulse) |
| ev_rstart_i | input | 1 | Repeated START seen (pulse) |
| ev_stop_i | input | 1 | STOP seen (pulse) |
| ev_addr_i | input | 1 | Address byte on `byte_i` (pulse) |
| ev_wdata_i | input | 1 | Written data byte on `byte_i` (pulse) |
| ev_rbyte_i | input | 1 | Current read byte has been shifted out (pulse) |
| byte_i | input | 8 | Received byte |
| ack_o | output | 1 | Acknowledge decision for the last address/data byte |
| rdata_o | output | 8 | Byte to transmit on the next read slot |
| alert_pull_o | output | 1 | 1 pulls the shared alert line low |

## Verification
The assertions assume the following about the front end:
- every event input is a one-cycle pulse;
- no two event pulses arrive in the same cycle;
- `byte_i` is valid while `ev_addr_i` or `ev_wdata_i` is high.

The properties on refused addresses and legal Read Byte sequences depend on these assumptions, because they compare the fault register across exactly one edge. The bench drives every event through a task that raises one pulse on a falling edge and drops it on the next. Events are therefore never adjacent within a cycle, and outputs are sampled after the single register stage.

// File: rtl/pmbus_alert_pkg.sv
package pmbus_alert_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] ARA_ADDR = 7'h0C;

    localparam logic [BYTE_W-1:0] CODE_RUN   = 8'h01;
    localparam logic [BYTE_W-1:0] CODE_CLEAR = 8'h03;
    localparam logic [BYTE_W-1:0] CODE_SUM   = 8'h78;
    localparam logic [BYTE_W-1:0] CODE_WORD  = 8'h79;
    localparam logic [BYTE_W-1:0] CODE_COMM  = 8'h7E;

    localparam int COMM_BAD_CMD  = 7;
    localparam int COMM_BAD_DATA = 6;
    localparam int SUM_COMM_BIT  = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_RD_REG,
        ST_RD_ARA,
        ST_RD_BAD,
        ST_SKIP
    } tgt_state_t;

    typedef enum logic [1:0] {
        RSRC_REG,
        RSRC_ARA,
        RSRC_BAD
    } rd_src_t;

    function automatic logic code_readable(input logic [BYTE_W-1:0] c);
        return (c == CODE_RUN) || (c == CODE_SUM) || (c == CODE_WORD) || (c == CODE_COMM);
    endfunction

    function automatic logic code_read_only(input logic [BYTE_W-1:0] c);
        return (c == CODE_SUM) || (c == CODE_WORD) || (c == CODE_COMM);
    endfunction

    function automatic logic code_decoded(input logic [BYTE_W-1:0] c);
        return code_readable(c) || (c == CODE_CLEAR);
    endfunction

endpackage

// File: rtl/pmbus_addr_match.sv
module pmbus_addr_match
    import pmbus_alert_pkg::*;
(
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic              alert_pend,
    output logic              hit_own_wr,
    output logic              hit_own_rd,
    output logic              hit_ara_rd
);
    logic [ADDR_W-1:0] addr7;
    logic              rd_bit;

    always_comb begin
        addr7      = addr_byte[BYTE_W-1:1];
        rd_bit     = addr_byte[0];
        hit_own_wr = (addr7 == own_addr) && !rd_bit;
        hit_own_rd = (addr7 == own_addr) && rd_bit;
        hit_ara_rd = (addr7 == ARA_ADDR) && rd_bit && alert_pend;
    end
endmodule

// File: rtl/pmbus_comm_status.sv
module pmbus_comm_status
    import pmbus_alert_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_bad_cmd,
    input  logic              set_bad_data,
    input  logic              clr_all,
    input  logic              ara_done,
    output logic [BYTE_W-1:0] comm_q,
    output logic              alert_pend_q
);
    logic any_set;

    always_comb any_set = set_bad_cmd || set_bad_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            comm_q       <= '0;
            alert_pend_q <= 1'b0;
        end else if (clr_all) begin
            comm_q       <= '0;
            alert_pend_q <= 1'b0;
        end else begin
            if (set_bad_cmd)  comm_q[COMM_BAD_CMD]  <= 1'b1;
            if (set_bad_data) comm_q[COMM_BAD_DATA] <= 1'b1;
            if (any_set)       alert_pend_q <= 1'b1;
            else if (ara_done) alert_pend_q <= 1'b0;
        end
    end

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (comm_q == '0) && !alert_pend_q);

    assert_fault_raises_alert_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (any_set && !clr_all) |=> alert_pend_q);

    assert_alert_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        alert_pend_q |-> (comm_q != '0));

    assert_ara_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ara_done && !any_set) |=> !alert_pend_q);
endmodule

// File: rtl/pmbus_rd_mux.sv
module pmbus_rd_mux
    import pmbus_alert_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  rd_src_t           src,
    input  logic [BYTE_W-1:0] cmd,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] comm,
    input  logic [BYTE_W-1:0] run_val,
    input  logic [ADDR_W-1:0] own_addr,
    output logic [BYTE_W-1:0] data
);
    logic [BYTE_W-1:0] summary;

    always_comb begin
        summary               = '0;
        summary[SUM_COMM_BIT] = |comm;
        data                  = '1;
        unique case (src)
            RSRC_ARA: data = (idx == '0) ? {own_addr, 1'b0} : '1;
            RSRC_REG: begin
                if (idx == '0) begin
                    if (cmd == CODE_SUM || cmd == CODE_WORD) data = summary;
                    else if (cmd == CODE_COMM)              data = comm;
                    else if (cmd == CODE_RUN)               data = run_val;
                end else if (idx == IDX_W'(1) && cmd == CODE_WORD) begin
                    data = '0;
                end
            end
            default: data = '1;
        endcase
    end
endmodule

// File: rtl/pmbus_alert_target.sv
module pmbus_alert_target
    import pmbus_alert_pkg::*;
#(
    parameter int                IDX_W     = 2,
    parameter logic [BYTE_W-1:0] RUN_RESET = 8'h00,
    parameter logic [BYTE_W-1:0] RUN_OFF   = 8'h00,
    parameter logic [BYTE_W-1:0] RUN_ON    = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              ev_start_i,
    input  logic              ev_rstart_i,
    input  logic              ev_stop_i,
    input  logic              ev_addr_i,
    input  logic              ev_wdata_i,
    input  logic              ev_rbyte_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              ack_o,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              alert_pull_o
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    tgt_state_t        state_q, state_d;
    rd_src_t           rsrc_q, rsrc_d;
    logic [BYTE_W-1:0] cmd_q, cmd_d;
    logic              data_seen_q, data_seen_d;
    logic              rd_ok_q, rd_ok_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [ADDR_W-1:0] own_q;
    logic [BYTE_W-1:0] run_q;

    logic              set_cmd, set_data, clr_all, ara_done, run_we;
    logic              acc, any_ev, load_rd;
    logic              hit_own_wr, hit_own_rd, hit_ara_rd;
    logic [BYTE_W-1:0] comm_q, rd_next;
    logic              alert_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) own_q <= own_addr_i;
        else        own_q <= own_q;
    end

    pmbus_addr_match u_match (
        .own_addr   (own_q),
        .addr_byte  (byte_i),
        .alert_pend (alert_pend),
        .hit_own_wr (hit_own_wr),
        .hit_own_rd (hit_own_rd),
        .hit_ara_rd (hit_ara_rd)
    );

    pmbus_comm_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_bad_cmd  (set_cmd),
        .set_bad_data (set_data),
        .clr_all      (clr_all),
        .ara_done     (ara_done),
        .comm_q       (comm_q),
        .alert_pend_q (alert_pend)
    );

    pmbus_rd_mux #(.IDX_W(IDX_W)) u_mux (
        .src      (rsrc_d),
        .cmd      (cmd_q),
        .idx      (idx_d),
        .comm     (comm_q),
        .run_val  (run_q),
        .own_addr (own_q),
        .data     (rd_next)
    );

    // Next-state and transaction decode
    always_comb begin
        state_d     = state_q;
        rsrc_d      = rsrc_q;
        cmd_d       = cmd_q;
        data_seen_d = data_seen_q;
        rd_ok_d     = rd_ok_q;
        idx_d       = idx_q;
        set_cmd     = 1'b0;
        set_data    = 1'b0;
        clr_all     = 1'b0;
        ara_done    = 1'b0;
        run_we      = 1'b0;
        acc         = 1'b0;
        load_rd     = 1'b0;
        if (ev_start_i) begin
            state_d = ST_ADDR;
            rd_ok_d = 1'b0;
        end else if (ev_rstart_i) begin
            rd_ok_d = (state_q == ST_WDATA) && !data_seen_q;
            state_d = ST_ADDR;
        end else if (ev_stop_i) begin
            if (state_q == ST_WDATA && cmd_q == CODE_CLEAR && !data_seen_q) clr_all = 1'b1;
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_ADDR: if (ev_addr_i) begin
                    idx_d = '0;
                    if (hit_ara_rd) begin
                        acc     = 1'b1;
                        load_rd = 1'b1;
                        rsrc_d  = RSRC_ARA;
                        state_d = ST_RD_ARA;
                    end else if (hit_own_wr) begin
                        acc     = 1'b1;
                        state_d = ST_CMD;
                    end else if (hit_own_rd) begin
                        acc     = 1'b1;
                        load_rd = 1'b1;
                        if (rd_ok_q) begin
                            rsrc_d  = RSRC_REG;
                            state_d = ST_RD_REG;
                            if (!code_readable(cmd_q)) set_cmd = 1'b1;
                        end else begin
                            rsrc_d   = RSRC_BAD;
                            state_d  = ST_RD_BAD;
                            set_data = 1'b1;
                        end
                    end else begin
                        state_d = ST_SKIP;
                    end
                end
                ST_CMD: if (ev_wdata_i) begin
                    acc         = 1'b1;
                    cmd_d       = byte_i;
                    data_seen_d = 1'b0;
                    state_d     = ST_WDATA;
                    if (!code_decoded(byte_i)) set_cmd = 1'b1;
                end
                ST_WDATA: if (ev_wdata_i) begin
                    acc         = 1'b1;
                    data_seen_d = 1'b1;
                    if (cmd_q == CODE_RUN && !data_seen_q) begin
                        if (byte_i == RUN_ON || byte_i == RUN_OFF) run_we = 1'b1;
                        else                                      set_data = 1'b1;
                    end else if (code_decoded(cmd_q)) begin
                        set_data = 1'b1;
                    end
                end
                ST_RD_ARA: if (ev_rbyte_i) begin
                    ara_done = 1'b1;
                    load_rd  = 1'b1;
                    rsrc_d   = RSRC_BAD;
                    state_d  = ST_RD_BAD;
                end
                ST_RD_REG, ST_RD_BAD: if (ev_rbyte_i) begin
                    load_rd = 1'b1;
                    if (idx_q != IDX_MAX) idx_d = idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            rsrc_q      <= RSRC_BAD;
            cmd_q       <= '0;
            data_seen_q <= 1'b0;
            rd_ok_q     <= 1'b0;
            idx_q       <= '0;
            run_q       <= RUN_RESET;
        end else begin
            state_q     <= state_d;
            rsrc_q      <= rsrc_d;
            cmd_q       <= cmd_d;
            data_seen_q <= data_seen_d;
            rd_ok_q     <= rd_ok_d;
            idx_q       <= idx_d;
            if (run_we) run_q <= byte_i;
        end
    end

    // Outputs
    always_comb any_ev = ev_start_i || ev_rstart_i || ev_stop_i || ev_addr_i || ev_wdata_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_o   <= 1'b0;
            rdata_o <= '1;
        end else begin
            if (any_ev)  ack_o   <= acc;
            if (load_rd) rdata_o <= rd_next;
        end
    end

    always_comb alert_pull_o = alert_pend;

    assert_ara_refused_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && ev_addr_i && byte_i[BYTE_W-1:1] == ARA_ADDR && !alert_pend)
        |=> !ack_o);

    assert_foreign_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && ev_addr_i && byte_i[BYTE_W-1:1] != own_q
         && byte_i[BYTE_W-1:1] != ARA_ADDR)
        |=> !ack_o && $stable(comm_q) && $stable(alert_pull_o));

    assert_read_byte_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && ev_addr_i && byte_i == {own_q, 1'b1} && rd_ok_q
         && code_readable(cmd_q))
        |=> ack_o && $stable(comm_q));

    assert_receive_byte_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && ev_addr_i && byte_i == {own_q, 1'b1} && !rd_ok_q)
        |=> ack_o && comm_q[COMM_BAD_DATA] && alert_pull_o);

    assert_ara_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && ev_addr_i && byte_i[BYTE_W-1:1] == ARA_ADDR && byte_i[0]
         && alert_pend)
        |=> ack_o && rdata_o == {own_q, 1'b0});
endmodule

// File: tb/pmbus_alert_target_test.sv
`timescale 1ns/1ps
module pmbus_alert_target_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] own_addr_i;
    logic       ev_start_i, ev_rstart_i, ev_stop_i, ev_addr_i, ev_wdata_i, ev_rbyte_i;
    logic [7:0] byte_i;
    logic       ack_o;
    logic [7:0] rdata_o;
    logic       alert_pull_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pmbus_alert_target uut (
        .clk(clk), .rst_n(rst_n), .own_addr_i(own_addr_i),
        .ev_start_i(ev_start_i), .ev_rstart_i(ev_rstart_i), .ev_stop_i(ev_stop_i),
        .ev_addr_i(ev_addr_i), .ev_wdata_i(ev_wdata_i), .ev_rbyte_i(ev_rbyte_i),
        .byte_i(byte_i), .ack_o(ack_o), .rdata_o(rdata_o), .alert_pull_o(alert_pull_o)
    );

    // {expected ack, address byte}; own address 0x38 strapped, input later moved to 0x11
    localparam int NPROBE = 7;
    localparam logic [8:0] PROBE [NPROBE] = '{
        9'h170, 9'h022, 9'h023, 9'h018, 9'h019, 9'h0A0, 9'h0FE
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kind: 0 start, 1 rstart, 2 stop, 3 addr, 4 wdata, 5 rbyte
    task automatic ev(input int kind, input logic [7:0] b);
        byte_i      = b;
        ev_start_i  = (kind == 0);
        ev_rstart_i = (kind == 1);
        ev_stop_i   = (kind == 2);
        ev_addr_i   = (kind == 3);
        ev_wdata_i  = (kind == 4);
        ev_rbyte_i  = (kind == 5);
        @(negedge clk);
        {ev_start_i, ev_rstart_i, ev_stop_i, ev_addr_i, ev_wdata_i, ev_rbyte_i} = '0;
        byte_i = 8'h00;
    endtask

    task automatic rd_reg(input logic [7:0] code, output logic [7:0] d0, output logic [7:0] d1);
        ev(0, 8'h00); ev(3, 8'h70); ev(4, code); ev(1, 8'h00); ev(3, 8'h71);
        d0 = rdata_o;
        ev(5, 8'h00);
        d1 = rdata_o;
        ev(2, 8'h00);
    endtask

    task automatic wr_reg(input logic [7:0] code, input bit has_data, input logic [7:0] d);
        ev(0, 8'h00); ev(3, 8'h70); ev(4, code);
        if (has_data) ev(4, d);
        ev(2, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d0, d1;
        {ev_start_i, ev_rstart_i, ev_stop_i, ev_addr_i, ev_wdata_i, ev_rbyte_i} = '0;
        byte_i     = 8'h00;
        own_addr_i = 7'h38;
        rst_n      = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        own_addr_i = 7'h11;  // R12: must be ignored after reset

        check("R1 ack", {7'h0, ack_o}, 8'h00);
        check("R1 alert", {7'h0, alert_pull_o}, 8'h00);
        rd_reg(8'h7E, d0, d1);
        check("R1 comm reset", d0, 8'h00);
        rd_reg(8'h01, d0, d1);
        check("R1 run reset", d0, 8'h00);

        // Address table walk: R2, R3, R12
        for (int i = 0; i < NPROBE; i++) begin
            ev(0, 8'h00);
            ev(3, PROBE[i][7:0]);
            check($sformatf("R2/R3/R12 probe %h", PROBE[i][7:0]), {7'h0, ack_o}, {7'h0, PROBE[i][8]});
            ev(2, 8'h00);
        end
        check("R2 no alert after probes", {7'h0, alert_pull_o}, 8'h00);
        rd_reg(8'h7E, d0, d1);
        check("R2 comm quiet", d0, 8'h00);

        // R7 legal run value, then out of range
        wr_reg(8'h01, 1'b1, 8'h80);
        rd_reg(8'h01, d0, d1);
        check("R7 run legal", d0, 8'h80);
        check("R6 read byte no alert", {7'h0, alert_pull_o}, 8'h00);
        wr_reg(8'h01, 1'b1, 8'h55);
        check("R11 alert after bad data", {7'h0, alert_pull_o}, 8'h01);
        rd_reg(8'h7E, d0, d1);
        check("R7 bad data bit6", d0, 8'h40);
        rd_reg(8'h01, d0, d1);
        check("R7 run kept", d0, 8'h80);

        // R4 alert response
        ev(0, 8'h00); ev(3, 8'h19);
        check("R3 ara ack pending", {7'h0, ack_o}, 8'h01);
        check("R4 ara data", rdata_o, 8'h70);
        check("R11 alert held before consume", {7'h0, alert_pull_o}, 8'h01);
        ev(5, 8'h00);
        check("R4 alert released", {7'h0, alert_pull_o}, 8'h00);
        ev(2, 8'h00);
        ev(0, 8'h00); ev(3, 8'h19);
        check("R4 ara refused after", {7'h0, ack_o}, 8'h00);
        ev(2, 8'h00);

        // R9 status reads with bit6 still set
        rd_reg(8'h78, d0, d1);
        check("R9 summary", d0, 8'h02);
        check("R9 summary second byte", d1, 8'hFF);
        rd_reg(8'h79, d0, d1);
        check("R9 word low", d0, 8'h02);
        check("R9 word high", d1, 8'h00);
        rd_reg(8'h7E, d0, d1);
        check("R4 fault bits kept", d0, 8'h40);

        // R8 clear faults
        wr_reg(8'h03, 1'b0, 8'h00);
        rd_reg(8'h7E, d0, d1);
        check("R8 cleared", d0, 8'h00);
        rd_reg(8'h78, d0, d1);
        check("R9 summary clear", d0, 8'h00);

        // R5 receive byte protocol error
        ev(0, 8'h00); ev(3, 8'h71);
        check("R5 ack", {7'h0, ack_o}, 8'h01);
        check("R5 data", rdata_o, 8'hFF);
        check("R5 alert", {7'h0, alert_pull_o}, 8'h01);
        ev(5, 8'h00); ev(2, 8'h00);
        rd_reg(8'h7E, d0, d1);
        check("R5 bit6", d0, 8'h40);
        wr_reg(8'h03, 1'b0, 8'h00);
        check("R8 alert cleared", {7'h0, alert_pull_o}, 8'h00);

        // R8 clear with data is not a clear
        wr_reg(8'h03, 1'b1, 8'h00);
        check("R8 data after clear alerts", {7'h0, alert_pull_o}, 8'h01);
        rd_reg(8'h7E, d0, d1);
        check("R8 data after clear bit6", d0, 8'h40);
        wr_reg(8'h03, 1'b0, 8'h00);

        // R7 write to read-only
        wr_reg(8'h79, 1'b1, 8'h12);
        rd_reg(8'h7E, d0, d1);
        check("R7 read-only write", d0, 8'h40);
        wr_reg(8'h03, 1'b0, 8'h00);

        // R10 unsupported code
        rd_reg(8'h5A, d0, d1);
        check("R10 unsupported data", d0, 8'hFF);
        check("R11 alert on bad cmd", {7'h0, alert_pull_o}, 8'h01);
        rd_reg(8'h7E, d0, d1);
        check("R10 bit7", d0, 8'h80);

        // R11 repeated fault re-raises alert after acknowledge
        ev(0, 8'h00); ev(3, 8'h19); ev(5, 8'h00); ev(2, 8'h00);
        check("R11 released", {7'h0, alert_pull_o}, 8'h00);
        rd_reg(8'h5A, d0, d1);
        check("R11 repeat fault raises", {7'h0, alert_pull_o}, 8'h01);
        wr_reg(8'h03, 1'b0, 8'h00);
        check("R8 final clear", {7'h0, alert_pull_o}, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule